// File: doc/BRIEF.md
# Host Interrupt Acknowledge Controller

This block keeps the pending-interrupt state of a two-channel network adapter and clears it on host acknowledge writes. Two adapter-wide sources (a status interrupt and a statistics interrupt) are held as single flags. For each channel and direction (transmit, receive) it holds a channel-end flag and a frame-completion counter. Adapter logic raises these through one-cycle event inputs.

The host issues a complete command in one write cycle. The write carries an acknowledge bit, three qualifier bits (per-channel scope, channel-end, receive), an 8-bit channel select and an acknowledge count. The qualifiers pick one of six clear actions. Frame acknowledges subtract the count from the selected counter. If the count is larger than what is outstanding, a sticky error is raised and the counter is left as it was.

A registered summary reports the highest-priority pending source. After a frame acknowledge, the summary is frozen for a fixed number of cycles before it follows the pending state again.

Top module: `host_int_ack_ctrl`

## Requirements
- R1: A command write with `cmd_ack` = 0 changes no pending flag and no counter, and `ack_rd` always reads 0.
- R2: An acknowledge write clears the status flag when the qualifiers are (per_chan,end_chan,rx) = (0,1,1), and clears the statistics flag when they are (0,0,1). Any qualifier value with per_chan = 0 and rx = 0 changes nothing.
- R3: An acknowledge write with per_chan = 1 and end_chan = 1 clears the channel-end flag of the selected channel. rx = 0 selects transmit and rx = 1 selects receive.
- R4: An acknowledge write with per_chan = 1 and end_chan = 0 subtracts `cmd_count` from the frame counter of the selected channel. rx = 0 selects the transmit counter and rx = 1 selects the receive counter.
- R5: A frame acknowledge whose count exceeds the selected counter leaves that counter unchanged and sets `ack_err`. `ack_err` stays set until reset.
- R6: A frame event adds one to its counter and saturates at 2^CNT_W-1. If an event arrives in the same cycle as an acknowledge, the event is counted after the subtraction.
- R7: If a flag's event and its clear arrive in the same cycle, the flag ends set.
- R8: A frame acknowledge write (valid or erroneous) sampled at edge N freezes `int_pend`/`int_src` through edge N+SUM_DELAY-1. At edge N+SUM_DELAY they take the encoding of the pending state, and a further frame acknowledge restarts the freeze.
- R9: Outside a freeze, `int_pend`/`int_src` show, one cycle later, the first pending source in this order: status = code 0, statistics = code 1, then for channel c the codes 2+4c+k, with k = 0 for receive channel-end, 1 for receive frames, 2 for transmit channel-end and 3 for transmit frames. A counter counts as pending while it is nonzero. With nothing pending, `int_pend` = 0 and `int_src` = 0.
- R10: Every command write loads the select field. `sel_rd` returns the written least significant bit with bits 7..1 zero. The command in the same write acts on channel `cmd_sel[0]`.
- R11: After synchronous reset, all flags, counters, `ack_err`, `sel_rd`, `int_pend` and `int_src` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_status | input | 1 | Status interrupt event |
| ev_stats | input | 1 | Statistics interrupt event |
| ev_chend_tx | input | NUM_CH | Transmit channel-end events, one per channel |
| ev_chend_rx | input | NUM_CH | Receive channel-end events |
| ev_frame_tx | input | NUM_CH | Transmit frame-complete events |
| ev_frame_rx | input | NUM_CH | Receive frame-complete events |
| cmd_we | input | 1 | Command register write strobe |
| cmd_ack | input | 1 | Acknowledge bit of the write |
| cmd_per_chan | input | 1 | Qualifier: per-channel scope |
| cmd_end_chan | input | 1 | Qualifier: channel-end (1) or frame (0) |
| cmd_rx | input | 1 | Qualifier: receive (1) or transmit (0) |
| cmd_sel | input | 8 | Channel select field |
| cmd_count | input | CNT_W | Frame acknowledge count |
| status_pend | output | 1 | Status interrupt pending |
| stats_pend | output | 1 | Statistics interrupt pending |
| chend_tx_pend | output | NUM_CH | Transmit channel-end flags |
| chend_rx_pend | output | NUM_CH | Receive channel-end flags |
| frame_tx_cnt | output | NUM_CH*CNT_W | Transmit frame counters, channel c at bits c*CNT_W upward |
| frame_rx_cnt | output | NUM_CH*CNT_W | Receive frame counters, same packing |
| ack_err | output | 1 | Sticky over-acknowledge error |
| int_pend | output | 1 | Summary: some source pending |
| int_src | output | SRC_W | Summary: code of the first pending source |
| sel_rd | output | 8 | Read-back of the channel select field |
| ack_rd | output | 1 | Read-back of the acknowledge bit |

## Verification
The bench builds the block with its defaults: two channels, 8-bit counters and a six-cycle freeze. With these values, saturation is reached after 255 events, so a run of about 300 events held against a same-cycle acknowledge tests R6 directly. Every code of the ten-entry summary is reachable. The short freeze lets back-to-back frame acknowledges land inside a running freeze and restart it. Long random phases, including over-acknowledges and a mid-run reset, are compared cycle by cycle against a behavioural model.

// File: rtl/hiac_pkg.sv
package hiac_pkg;

    localparam int SEL_FIELD_W  = 8;
    localparam int GLOBAL_SRCS  = 2;
    localparam int SLOTS_PER_CH = 4;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_STATUS,
        ACT_STATS,
        ACT_CHEND_TX,
        ACT_CHEND_RX,
        ACT_FRAME_TX,
        ACT_FRAME_RX
    } ack_act_e;

    typedef struct packed {
        ack_act_e               act;
        logic [SEL_FIELD_W-1:0] ch;
    } ack_cmd_t;

    // Summary slot offsets inside one channel's group (priority order)
    localparam int SLOT_RX_END   = 0;
    localparam int SLOT_RX_FRAME = 1;
    localparam int SLOT_TX_END   = 2;
    localparam int SLOT_TX_FRAME = 3;

    function automatic ack_act_e decode_qual(input logic per_chan,
                                             input logic end_chan,
                                             input logic rx);
        if (!per_chan)
            return rx ? (end_chan ? ACT_STATUS : ACT_STATS) : ACT_NONE;
        else if (end_chan)
            return rx ? ACT_CHEND_RX : ACT_CHEND_TX;
        else
            return rx ? ACT_FRAME_RX : ACT_FRAME_TX;
    endfunction

    function automatic int chan_base(input int ch);
        return GLOBAL_SRCS + SLOTS_PER_CH * ch;
    endfunction

endpackage

// File: rtl/hiac_cmd_decode.sv
module hiac_cmd_decode
    import hiac_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic                   wr_ack,
    input  logic                   wr_per_chan,
    input  logic                   wr_end_chan,
    input  logic                   wr_rx,
    input  logic [SEL_FIELD_W-1:0] wr_sel,
    output ack_cmd_t               cmd,
    output logic [SEL_FIELD_W-1:0] sel_rd
);

    logic [CH_W-1:0] sel_q;
    logic            unused_sel_hi;

    assign unused_sel_hi = ^wr_sel[SEL_FIELD_W-1:CH_W];

    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= '0;
        else if (wr_en)
            sel_q <= wr_sel[CH_W-1:0];
    end

    assign sel_rd = {{(SEL_FIELD_W-CH_W){1'b0}}, sel_q};

    always_comb begin
        cmd.ch  = {{(SEL_FIELD_W-CH_W){1'b0}}, wr_sel[CH_W-1:0]};
        cmd.act = (wr_en && wr_ack) ? decode_qual(wr_per_chan, wr_end_chan, wr_rx)
                                    : ACT_NONE;
    end

    // R10: select read-back follows the last write
    a_r10_sel_load: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> sel_rd[CH_W-1:0] == $past(wr_sel[CH_W-1:0]));

    a_r10_sel_keep: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(sel_rd));

endmodule

// File: rtl/hiac_frame_counter.sv
module hiac_frame_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             ack_en,
    input  logic [CNT_W-1:0] ack_cnt,
    output logic [CNT_W-1:0] cnt,
    output logic             err
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] after_ack;
    logic [CNT_W-1:0] cnt_next;
    logic             over;

    assign over = ack_en && (ack_cnt > cnt);
    assign err  = over;

    always_comb begin
        after_ack = (ack_en && !over) ? cnt - ack_cnt : cnt;
        cnt_next  = after_ack;
        if (inc && after_ack != CNT_MAX)
            cnt_next = after_ack + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else
            cnt <= cnt_next;
    end

    // R6: a full counter with no acknowledge stays at its ceiling
    a_r6_saturate: assert property (@(posedge clk) disable iff (rst)
        (inc && !ack_en && cnt == CNT_MAX) |=> cnt == CNT_MAX);

    // R5: rejected acknowledge leaves the count untouched
    a_r5_err_keep: assert property (@(posedge clk) disable iff (rst)
        (ack_en && ack_cnt > cnt && !inc) |=> $stable(cnt));

    // R4: accepted acknowledge lowers the count
    a_r4_sub: assert property (@(posedge clk) disable iff (rst)
        (ack_en && ack_cnt <= cnt && !inc) |=> cnt + $past(ack_cnt) == $past(cnt));

    // R6: an event with no acknowledge never lowers the count
    a_r6_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (inc && !ack_en) |=> cnt >= $past(cnt));

endmodule

// File: rtl/hiac_int_summary.sv
module hiac_int_summary #(
    parameter int NSRC   = 10,
    parameter int DELAY  = 6,
    localparam int SRC_W  = (NSRC > 1) ? $clog2(NSRC) : 1,
    localparam int HOLD_W = $clog2(DELAY + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  pend,
    input  logic             frame_ack,
    output logic             int_pend,
    output logic [SRC_W-1:0] int_src
);

    logic [HOLD_W-1:0] hold;
    logic              found;
    logic [SRC_W-1:0]  code;

    always_comb begin
        found = 1'b0;
        code  = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                found = 1'b1;
                code  = SRC_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold     <= '0;
            int_pend <= 1'b0;
            int_src  <= '0;
        end else if (frame_ack) begin
            hold <= HOLD_W'(DELAY - 1);
        end else if (hold != '0) begin
            hold <= hold - 1'b1;
        end else begin
            int_pend <= found;
            int_src  <= code;
        end
    end

    // R8: summary frozen while a frame acknowledge delay runs
    a_r8_frozen: assert property (@(posedge clk) disable iff (rst)
        (frame_ack || hold != '0) |=> ($stable(int_pend) && $stable(int_src)));

    // R9: idle summary with nothing pending reports nothing
    a_r9_idle_clear: assert property (@(posedge clk) disable iff (rst)
        (!frame_ack && hold == '0 && pend == '0) |=> (!int_pend && int_src == '0));

    a_r9_src_zero: assert property (@(posedge clk) disable iff (rst)
        !int_pend |-> int_src == '0);

endmodule

// File: rtl/host_int_ack_ctrl.sv
module host_int_ack_ctrl
    import hiac_pkg::*;
#(
    parameter int NUM_CH    = 2,
    parameter int CNT_W     = 8,
    parameter int SUM_DELAY = 6,
    localparam int NSRC     = GLOBAL_SRCS + SLOTS_PER_CH * NUM_CH,
    localparam int SRC_W    = $clog2(NSRC)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ev_status,
    input  logic                    ev_stats,
    input  logic [NUM_CH-1:0]       ev_chend_tx,
    input  logic [NUM_CH-1:0]       ev_chend_rx,
    input  logic [NUM_CH-1:0]       ev_frame_tx,
    input  logic [NUM_CH-1:0]       ev_frame_rx,
    input  logic                    cmd_we,
    input  logic                    cmd_ack,
    input  logic                    cmd_per_chan,
    input  logic                    cmd_end_chan,
    input  logic                    cmd_rx,
    input  logic [7:0]              cmd_sel,
    input  logic [CNT_W-1:0]        cmd_count,
    output logic                    status_pend,
    output logic                    stats_pend,
    output logic [NUM_CH-1:0]       chend_tx_pend,
    output logic [NUM_CH-1:0]       chend_rx_pend,
    output logic [NUM_CH*CNT_W-1:0] frame_tx_cnt,
    output logic [NUM_CH*CNT_W-1:0] frame_rx_cnt,
    output logic                    ack_err,
    output logic                    int_pend,
    output logic [SRC_W-1:0]        int_src,
    output logic [7:0]              sel_rd,
    output logic                    ack_rd
);

    ack_cmd_t          cmd;
    logic [NUM_CH-1:0] err_tx;
    logic [NUM_CH-1:0] err_rx;
    logic [NSRC-1:0]   pend_vec;
    logic              frame_ack;

    hiac_cmd_decode #(.NUM_CH(NUM_CH)) u_decode (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (cmd_we),
        .wr_ack      (cmd_ack),
        .wr_per_chan (cmd_per_chan),
        .wr_end_chan (cmd_end_chan),
        .wr_rx       (cmd_rx),
        .wr_sel      (cmd_sel),
        .cmd         (cmd),
        .sel_rd      (sel_rd)
    );

    assign ack_rd    = 1'b0;
    assign frame_ack = (cmd.act == ACT_FRAME_TX) || (cmd.act == ACT_FRAME_RX);

    // Adapter-wide flags: event wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (rst) begin
            status_pend <= 1'b0;
            stats_pend  <= 1'b0;
        end else begin
            if (ev_status)
                status_pend <= 1'b1;
            else if (cmd.act == ACT_STATUS)
                status_pend <= 1'b0;
            if (ev_stats)
                stats_pend <= 1'b1;
            else if (cmd.act == ACT_STATS)
                stats_pend <= 1'b0;
        end
    end

    assign pend_vec[0] = status_pend;
    assign pend_vec[1] = stats_pend;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int BASE = chan_base(c);

        logic             hit;
        logic             end_tx_q;
        logic             end_rx_q;
        logic [CNT_W-1:0] tx_cnt;
        logic [CNT_W-1:0] rx_cnt;

        assign hit = (cmd.ch == SEL_FIELD_W'(c));

        always_ff @(posedge clk) begin
            if (rst) begin
                end_tx_q <= 1'b0;
                end_rx_q <= 1'b0;
            end else begin
                if (ev_chend_tx[c])
                    end_tx_q <= 1'b1;
                else if (hit && cmd.act == ACT_CHEND_TX)
                    end_tx_q <= 1'b0;
                if (ev_chend_rx[c])
                    end_rx_q <= 1'b1;
                else if (hit && cmd.act == ACT_CHEND_RX)
                    end_rx_q <= 1'b0;
            end
        end

        hiac_frame_counter #(.CNT_W(CNT_W)) u_tx_cnt (
            .clk     (clk),
            .rst     (rst),
            .inc     (ev_frame_tx[c]),
            .ack_en  (hit && cmd.act == ACT_FRAME_TX),
            .ack_cnt (cmd_count),
            .cnt     (tx_cnt),
            .err     (err_tx[c])
        );

        hiac_frame_counter #(.CNT_W(CNT_W)) u_rx_cnt (
            .clk     (clk),
            .rst     (rst),
            .inc     (ev_frame_rx[c]),
            .ack_en  (hit && cmd.act == ACT_FRAME_RX),
            .ack_cnt (cmd_count),
            .cnt     (rx_cnt),
            .err     (err_rx[c])
        );

        assign chend_tx_pend[c]              = end_tx_q;
        assign chend_rx_pend[c]              = end_rx_q;
        assign frame_tx_cnt[c*CNT_W +: CNT_W] = tx_cnt;
        assign frame_rx_cnt[c*CNT_W +: CNT_W] = rx_cnt;

        assign pend_vec[BASE + SLOT_RX_END]   = end_rx_q;
        assign pend_vec[BASE + SLOT_RX_FRAME] = (rx_cnt != '0);
        assign pend_vec[BASE + SLOT_TX_END]   = end_tx_q;
        assign pend_vec[BASE + SLOT_TX_FRAME] = (tx_cnt != '0);
    end

    always_ff @(posedge clk) begin
        if (rst)
            ack_err <= 1'b0;
        else if ((|err_tx) || (|err_rx))
            ack_err <= 1'b1;
    end

    hiac_int_summary #(.NSRC(NSRC), .DELAY(SUM_DELAY)) u_summary (
        .clk       (clk),
        .rst       (rst),
        .pend      (pend_vec),
        .frame_ack (frame_ack),
        .int_pend  (int_pend),
        .int_src   (int_src)
    );

    // R5: error flag is sticky
    a_r5_err_sticky: assert property (@(posedge clk) disable iff (rst)
        ack_err |=> ack_err);

    // R1: a write without the acknowledge bit leaves the status flag alone
    a_r1_no_ack_noop: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && !cmd_ack && !ev_status) |=> $stable(status_pend));

    // R2: status acknowledge clears the status flag
    a_r2_status_clear: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && cmd_ack && !cmd_per_chan && cmd_end_chan && cmd_rx && !ev_status)
        |=> !status_pend);

    // R2: per_chan=0, rx=0 is a no-op on the statistics flag
    a_r2_noop_qual: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && !cmd_per_chan && !cmd_rx && !ev_stats) |=> $stable(stats_pend));

    // R7: an event always leaves its flag set
    a_r7_event_wins: assert property (@(posedge clk) disable iff (rst)
        ev_status |=> status_pend);

    // R3: receive channel-end acknowledge on channel 0 clears that flag
    a_r3_chend_clear: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && cmd_ack && cmd_per_chan && cmd_end_chan && cmd_rx
         && cmd_sel[0] == 1'b0 && !ev_chend_rx[0]) |=> !chend_rx_pend[0]);

endmodule

// File: tb/host_int_ack_ctrl_bench.sv
`timescale 1ns/1ps
module host_int_ack_ctrl_bench;

    localparam int NUM_CH = 2;
    localparam int CNT_W  = 8;
    localparam int DLY    = 6;
    localparam int SRC_W  = 4;
    localparam int CMAX   = 255;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                    rst;
    logic                    ev_status, ev_stats;
    logic [NUM_CH-1:0]       ev_chend_tx, ev_chend_rx, ev_frame_tx, ev_frame_rx;
    logic                    cmd_we, cmd_ack, cmd_per_chan, cmd_end_chan, cmd_rx;
    logic [7:0]              cmd_sel;
    logic [CNT_W-1:0]        cmd_count;
    logic                    status_pend, stats_pend, ack_err, int_pend, ack_rd;
    logic [NUM_CH-1:0]       chend_tx_pend, chend_rx_pend;
    logic [NUM_CH*CNT_W-1:0] frame_tx_cnt, frame_rx_cnt;
    logic [SRC_W-1:0]        int_src;
    logic [7:0]              sel_rd;

    host_int_ack_ctrl u_host_int_ack_ctrl (
        .clk(clk), .rst(rst),
        .ev_status(ev_status), .ev_stats(ev_stats),
        .ev_chend_tx(ev_chend_tx), .ev_chend_rx(ev_chend_rx),
        .ev_frame_tx(ev_frame_tx), .ev_frame_rx(ev_frame_rx),
        .cmd_we(cmd_we), .cmd_ack(cmd_ack), .cmd_per_chan(cmd_per_chan),
        .cmd_end_chan(cmd_end_chan), .cmd_rx(cmd_rx),
        .cmd_sel(cmd_sel), .cmd_count(cmd_count),
        .status_pend(status_pend), .stats_pend(stats_pend),
        .chend_tx_pend(chend_tx_pend), .chend_rx_pend(chend_rx_pend),
        .frame_tx_cnt(frame_tx_cnt), .frame_rx_cnt(frame_rx_cnt),
        .ack_err(ack_err), .int_pend(int_pend), .int_src(int_src),
        .sel_rd(sel_rd), .ack_rd(ack_rd)
    );

    int total = 0;
    int bad   = 0;
    bit cmp_en = 1'b0;
    bit done   = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // dir index: 0 = transmit, 1 = receive
    bit m_status, m_stats, m_err;
    bit m_end[2][NUM_CH];
    int m_frm[2][NUM_CH];
    int m_sel, m_hold, m_isrc;
    bit m_ipend;

    function automatic int first_pending();
        if (m_status) return 0;
        if (m_stats)  return 1;
        for (int c = 0; c < NUM_CH; c++) begin
            if (m_end[1][c])    return 2 + 4*c;
            if (m_frm[1][c] > 0) return 3 + 4*c;
            if (m_end[0][c])    return 4 + 4*c;
            if (m_frm[0][c] > 0) return 5 + 4*c;
        end
        return -1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_status = 0; m_stats = 0; m_err = 0;
            m_sel = 0; m_hold = 0; m_isrc = 0; m_ipend = 0;
            for (int d = 0; d < 2; d++)
                for (int c = 0; c < NUM_CH; c++) begin
                    m_end[d][c] = 0;
                    m_frm[d][c] = 0;
                end
        end else begin
            int fp, ch, d;
            fp = first_pending();
            if (cmd_we && cmd_ack && cmd_per_chan && !cmd_end_chan)
                m_hold = DLY - 1;
            else if (m_hold > 0)
                m_hold--;
            else begin
                m_ipend = (fp >= 0);
                m_isrc  = (fp >= 0) ? fp : 0;
            end
            if (cmd_we) m_sel = cmd_sel[0];
            ch = cmd_sel[0];
            d  = cmd_rx ? 1 : 0;
            if (cmd_we && cmd_ack) begin
                if (!cmd_per_chan) begin
                    if (cmd_rx) begin
                        if (cmd_end_chan) m_status = 0;
                        else              m_stats  = 0;
                    end
                end else if (cmd_end_chan) begin
                    m_end[d][ch] = 0;
                end else if (int'(cmd_count) > m_frm[d][ch]) begin
                    m_err = 1;
                end else begin
                    m_frm[d][ch] -= int'(cmd_count);
                end
            end
            if (ev_status) m_status = 1;
            if (ev_stats)  m_stats  = 1;
            for (int c = 0; c < NUM_CH; c++) begin
                if (ev_chend_tx[c]) m_end[0][c] = 1;
                if (ev_chend_rx[c]) m_end[1][c] = 1;
                if (ev_frame_tx[c] && m_frm[0][c] < CMAX) m_frm[0][c]++;
                if (ev_frame_rx[c] && m_frm[1][c] < CMAX) m_frm[1][c]++;
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (cmp_en) begin
            chk("R2 status_pend", status_pend, m_status);
            chk("R2 stats_pend", stats_pend, m_stats);
            for (int c = 0; c < NUM_CH; c++) begin
                chk("R3 chend_tx_pend", chend_tx_pend[c], m_end[0][c]);
                chk("R3 chend_rx_pend", chend_rx_pend[c], m_end[1][c]);
                chk("R4 frame_tx_cnt", frame_tx_cnt[c*CNT_W +: CNT_W], m_frm[0][c]);
                chk("R4 frame_rx_cnt", frame_rx_cnt[c*CNT_W +: CNT_W], m_frm[1][c]);
            end
            chk("R5 ack_err", ack_err, m_err);
            chk("R8 int_pend", int_pend, m_ipend);
            chk("R9 int_src", int_src, m_isrc);
            chk("R10 sel_rd", sel_rd, m_sel);
            chk("R1 ack_rd", ack_rd, 0);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle();
        ev_status = 0; ev_stats = 0;
        ev_chend_tx = '0; ev_chend_rx = '0; ev_frame_tx = '0; ev_frame_rx = '0;
        cmd_we = 0; cmd_ack = 0; cmd_per_chan = 0; cmd_end_chan = 0; cmd_rx = 0;
        cmd_sel = '0; cmd_count = '0;
    endtask

    task automatic cycle();
        @(negedge clk);
    endtask

    task automatic wr(input bit ack, input bit pc, input bit ec, input bit rx,
                      input logic [7:0] sel, input int cnt);
        cmd_we = 1; cmd_ack = ack; cmd_per_chan = pc; cmd_end_chan = ec;
        cmd_rx = rx; cmd_sel = sel; cmd_count = CNT_W'(cnt);
        cycle();
        idle();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        idle();
        rst = 1;
        cycle();
        cycle();
        cmp_en = 1;
        // R11: reset state
        chk("R11 status_pend", status_pend, 0);
        chk("R11 int_pend", int_pend, 0);
        chk("R11 int_src", int_src, 0);
        chk("R11 frame_tx_cnt", frame_tx_cnt, 0);
        chk("R11 ack_err", ack_err, 0);
        chk("R11 sel_rd", sel_rd, 0);
        rst = 0;
        cycle();

        // R8 / R9: two tx frames on channel 0 -> code 5, then freeze after ack
        ev_frame_tx[0] = 1; cycle(); cycle(); idle();
        cycle();
        chk("R9 code tx frame ch0", int_src, 5);
        wr(1, 1, 0, 0, 8'h00, 2);
        chk("R4 tx ch0 after ack", frame_tx_cnt[7:0], 0);
        for (int k = 0; k < DLY; k++) begin
            chk("R8 frozen int_pend", int_pend, 1);
            cycle();
        end
        chk("R8 released int_pend", int_pend, 0);

        // R3: tx channel-end on channel 1 -> code 8, then clear
        ev_chend_tx[1] = 1; cycle(); idle();
        cycle();
        chk("R9 code tx end ch1", int_src, 8);
        wr(1, 1, 1, 0, 8'h01, 0);
        chk("R3 tx end ch1 cleared", chend_tx_pend[1], 0);

        // R1: acknowledge bit 0 has no effect
        ev_status = 1; cycle(); idle();
        wr(0, 0, 1, 1, 8'h00, 0);
        chk("R1 status kept", status_pend, 1);
        chk("R1 ack reads 0", ack_rd, 0);
        wr(1, 0, 1, 1, 8'h00, 0);
        chk("R2 status cleared", status_pend, 0);

        // R2: per_chan=0, rx=0 is a no-op; then clear statistics
        ev_stats = 1; cycle(); idle();
        wr(1, 0, 0, 0, 8'h00, 0);
        wr(1, 0, 1, 0, 8'h00, 0);
        chk("R2 noop keeps stats", stats_pend, 1);
        wr(1, 0, 0, 1, 8'h00, 0);
        chk("R2 stats cleared", stats_pend, 0);

        // R7: event and clear in the same cycle
        ev_status = 1;
        wr(1, 0, 1, 1, 8'h00, 0);
        chk("R7 event wins", status_pend, 1);
        wr(1, 0, 1, 1, 8'h00, 0);

        // R5: over-acknowledge
        ev_frame_rx[0] = 1; cycle(); idle();
        wr(1, 1, 0, 1, 8'h00, 3);
        chk("R5 error raised", ack_err, 1);
        chk("R5 counter kept", frame_rx_cnt[7:0], 1);
        repeat (4) cycle();
        chk("R5 error sticky", ack_err, 1);

        // R10: select read-back and same-write channel use
        wr(0, 0, 0, 0, 8'hFF, 0);
        chk("R10 sel lsb", sel_rd, 1);
        wr(0, 0, 0, 0, 8'h02, 0);
        chk("R10 sel upper zero", sel_rd, 0);
        ev_frame_rx[1] = 1; repeat (3) cycle(); idle();
        wr(1, 1, 0, 1, 8'h03, 2);
        chk("R10 acts on ch1", frame_rx_cnt[15:8], 1);
        chk("R10 sel after cmd", sel_rd, 1);

        // R6: saturation, then ack with same-cycle event
        ev_frame_rx[1] = 1; repeat (300) cycle();
        chk("R6 saturated", frame_rx_cnt[15:8], CMAX);
        wr(1, 1, 0, 1, 8'h01, 5);   // ev_frame_rx[1] still 1 in this cycle
        chk("R6 sub then add", frame_rx_cnt[15:8], CMAX - 5 + 1);

        // random phases, with a reset in between (R11)
        for (int ph = 0; ph < 2; ph++) begin
            rst = 1; cycle(); rst = 0;
            for (int n = 0; n < 4000; n++) begin
                ev_status   = ($urandom_range(0, 7) == 0);
                ev_stats    = ($urandom_range(0, 7) == 0);
                ev_chend_tx = 2'($urandom_range(0, 3) & $urandom_range(0, 3));
                ev_chend_rx = 2'($urandom_range(0, 3) & $urandom_range(0, 3));
                ev_frame_tx = 2'($urandom_range(0, 3));
                ev_frame_rx = 2'($urandom_range(0, 3));
                cmd_we       = ($urandom_range(0, 2) != 0);
                cmd_ack      = ($urandom_range(0, 3) != 0);
                cmd_per_chan = 1'($urandom_range(0, 1));
                cmd_end_chan = 1'($urandom_range(0, 1));
                cmd_rx       = 1'($urandom_range(0, 1));
                cmd_sel      = 8'($urandom_range(0, 255));
                cmd_count    = ($urandom_range(0, 15) == 0) ? CNT_W'($urandom_range(0, 255))
                                                            : CNT_W'($urandom_range(0, 3));
                cycle();
            end
            idle();
            repeat (DLY + 2) cycle();
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule